// File: doc/BRIEF.md
# Up-Counting Register Timer

This block is a 32-bit timer peripheral reached through a small synchronous register bus. Its counter counts up by one every clock while it runs. When it passes all-ones it either reloads from a reload register or wraps to zero, and it raises an overflow flag. A compare register raises a match flag when the running counter equals it. Each flag has its own interrupt-enable bit and wake-enable bit. Software clears a flag by writing one to it. Software can schedule an overflow N ticks ahead by loading the counter with the two's complement of N.

Writes to the control, counter, reload, trigger and compare registers are posted. Each one travels through a short delay line before it takes effect. A pending register shows which of these writes are still in flight, so software can poll it before relying on a new value. All other registers take a write on the clock edge that samples it. Reads are combinational on the address and show the state left by the last edge. A soft reset returns every register to its default. A reset-done flag then reports when the block is ready again.

The bus has no back-pressure. A write is taken on every clock edge where `bus_sel` and `bus_wr` are both high, and read data never stalls. The control and status pins are plain levels.

Top module: `upcount_timer`

## Requirements
- R1: Offset 0x00 reads 0x21: the major revision 2 in bits 7:4, the minor revision 1 in bits 3:0, and zero above bit 7.
- R2: Writes to 0x24 (control), 0x28 (counter), 0x2C (reload), 0x30 (trigger) and 0x38 (compare) take effect on the second clock edge after the edge that samples the write. Offset 0x34 shows a pending bit for each of these registers for exactly the two cycles in between: bit 0 control, bit 1 counter, bit 2 reload, bit 3 trigger, bit 4 compare. Back-to-back writes to the same register land in the order they were written.
- R3: While control bit 0 is 1, the counter at 0x28 increases by one on every clock edge. While bit 0 is 0, the counter holds its value.
- R4: On the edge where a running counter leaves all-ones, it loads the reload value if control bit 1 is 1, or zero if bit 1 is 0. Status bit 1 (overflow) sets on that same edge.
- R5: When control bit 6 is 1, the counter is running and the counter equals the compare register, status bit 0 (match) sets on the next edge.
- R6: Status at 0x18 is write-one-to-clear. Writing 0 to a bit leaves it unchanged. Bit 2 (capture) is never set by this block. A flag set by hardware on the same edge as a clear stays set.
- R7: `irq` is 1 exactly when some status bit is set and its enable bit at 0x1C is also 1. `wake` does the same with the enables at 0x20. Bit positions follow the status register.
- R8: A landed write to the trigger register loads the counter from the reload register.
- R9: Writing 1 to bit 1 of 0x10 returns every register, including in-flight posted writes, to its reset value on that edge. Bit 0 of 0x14 (reset done) then reads 0 for one cycle and 1 afterwards. Offset 0x10 always reads 0. After a hard reset, reset done reads 1 from the first clock edge on.
- R10: Unmapped offsets and the trigger register read 0.
- R11: A landed counter write overrides the increment, the wrap and a trigger landing on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, taken when bus_sel is high |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt from the enabled status flags |
| wake | output | 1 | Level wake request from the wake-enabled status flags |

## Verification
A wrong counter value shows at offset 0x28 on the first read after the faulty edge. It spreads into the overflow and match flags, and from there into `irq`, some cycles later. A delay line of the wrong length moves the pending bits at 0x34 and the landing cycle by whole cycles, which the cycle-exact reads catch. The status flags, their clear path and the soft-reset defaults all show at 0x18, `irq` and `wake` one cycle after the edge that changed them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NFLAG  = 3;
  localparam int unsigned NPOST  = 5;

  // register offsets (software decodes these)
  localparam logic [7:0] A_ID   = 8'h00;
  localparam logic [7:0] A_CFG  = 8'h10;
  localparam logic [7:0] A_SYS  = 8'h14;
  localparam logic [7:0] A_STAT = 8'h18;
  localparam logic [7:0] A_IEN  = 8'h1C;
  localparam logic [7:0] A_WEN  = 8'h20;
  localparam logic [7:0] A_CTRL = 8'h24;
  localparam logic [7:0] A_CNT  = 8'h28;
  localparam logic [7:0] A_RLD  = 8'h2C;
  localparam logic [7:0] A_TRG  = 8'h30;
  localparam logic [7:0] A_PEND = 8'h34;
  localparam logic [7:0] A_MAT  = 8'h38;

  // posted slots; index equals pending bit position
  typedef enum int unsigned {
    PS_CTRL = 0, PS_CNT = 1, PS_RLD = 2, PS_TRG = 3, PS_MAT = 4
  } post_slot_e;

  localparam int unsigned FL_MAT = 0;
  localparam int unsigned FL_OVF = 1;
  localparam int unsigned FL_CAP = 2;

  localparam int unsigned CT_RUN = 0;
  localparam int unsigned CT_AR  = 1;
  localparam int unsigned CT_CE  = 6;
  localparam int unsigned CFG_SRST = 1;

  function automatic logic [7:0] post_addr(int unsigned slot);
    case (slot)
      0:       return A_CTRL;
      1:       return A_CNT;
      2:       return A_RLD;
      3:       return A_TRG;
      default: return A_MAT;
    endcase
  endfunction
endpackage

// File: rtl/post_pipe.sv
module post_pipe #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         out_vld,
  output logic [W-1:0] out_data,
  output logic         busy
);
  logic [DEPTH-1:0] vld_q;
  logic [W-1:0]     dat_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vld_q[0] <= 1'b0;
    else if (clr) vld_q[0] <= 1'b0;
    else          vld_q[0] <= wr_en;
  end

  always_ff @(posedge clk) dat_q[0] <= wdata;

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q[s] <= 1'b0;
      else if (clr) vld_q[s] <= 1'b0;
      else          vld_q[s] <= vld_q[s-1];
    end
    always_ff @(posedge clk) dat_q[s] <= dat_q[s-1];
  end

  assign out_vld  = vld_q[DEPTH-1];
  assign out_data = dat_q[DEPTH-1];
  assign busy     = |vld_q;

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> busy);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en) |=> !out_vld);
endmodule

// File: rtl/count_core.sv
module count_core import tmr_pkg::*; #(
  parameter int unsigned W   = DATA_W,
  parameter int unsigned NFL = NFLAG
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           run,
  input  logic           auto_rld,
  input  logic           cmp_en,
  input  logic [W-1:0]   reload,
  input  logic [W-1:0]   match_val,
  input  logic           cnt_ld,
  input  logic [W-1:0]   cnt_ld_val,
  input  logic           trg,
  input  logic           w1c_we,
  input  logic [NFL-1:0] w1c_mask,
  output logic [W-1:0]   count,
  output logic [NFL-1:0] status
);
  logic [W-1:0]   count_q, cnt_d;
  logic [NFL-1:0] status_q, stat_d;
  logic           ovf_evt, mat_evt;

  assign ovf_evt = run && (&count_q);
  assign mat_evt = run && cmp_en && (count_q == match_val);

  always_comb begin
    cnt_d = count_q;
    if (cnt_ld)   cnt_d = cnt_ld_val;
    else if (trg) cnt_d = reload;
    else if (run) cnt_d = ovf_evt ? (auto_rld ? reload : '0)
                                  : count_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_comb begin
    stat_d = status_q;
    if (w1c_we) stat_d = stat_d & ~w1c_mask;
    if (ovf_evt) stat_d[FL_OVF] = 1'b1;
    if (mat_evt) stat_d[FL_MAT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      status_q <= '0;
    end else if (clr) begin
      count_q  <= '0;
      status_q <= '0;
    end else begin
      count_q  <= cnt_d;
      status_q <= stat_d;
    end
  end

  assign count  = count_q;
  assign status = status_q;

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_ld && !trg && !clr && !(&count_q)) |=> count_q == $past(count_q) + 1'b1);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_ld && !trg && !clr) |=> $stable(count_q));
  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (&count_q) && !cnt_ld && !trg && !clr) |=>
      (count_q == ($past(auto_rld) ? $past(reload) : '0)) && status_q[FL_OVF]);
  // R5
  match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mat_evt && !clr) |=> status_q[FL_MAT]);
  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_we && w1c_mask[FL_MAT] && !mat_evt && !clr) |=> !status_q[FL_MAT]);
  // R6
  cap_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_q[FL_CAP] |=> !status_q[FL_CAP]);
  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ld && !clr) |=> count_q == $past(cnt_ld_val));
endmodule

// File: rtl/upcount_timer.sv
module upcount_timer import tmr_pkg::*; #(
  parameter logic [3:0]  REV_MAJOR  = 4'd2,
  parameter logic [3:0]  REV_MINOR  = 4'd1,
  parameter int unsigned POST_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        wake
);
  logic                 wr_any, soft_rst;
  logic [NPOST-1:0]     land, pend;
  logic [DATA_W-1:0]    ldat [NPOST];
  logic [DATA_W-1:0]    ctrl_q, reload_q, match_q, count_w;
  logic [NFLAG-1:0]     ien_q, wen_q, stat_w;
  logic                 done_q;

  assign wr_any   = bus_sel && bus_wr;
  assign soft_rst = wr_any && (bus_addr == A_CFG) && bus_wdata[CFG_SRST];

  for (genvar gi = 0; gi < NPOST; gi++) begin : g_post
    post_pipe #(.W(DATA_W), .DEPTH(POST_DEPTH)) u_pp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_rst),
      .wr_en    (wr_any && (bus_addr == post_addr(gi))),
      .wdata    (bus_wdata),
      .out_vld  (land[gi]),
      .out_data (ldat[gi]),
      .busy     (pend[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; reload_q <= '0; match_q <= '0;
      ien_q  <= '0; wen_q    <= '0; done_q  <= 1'b0;
    end else if (soft_rst) begin
      ctrl_q <= '0; reload_q <= '0; match_q <= '0;
      ien_q  <= '0; wen_q    <= '0; done_q  <= 1'b0;
    end else begin
      done_q <= 1'b1;
      if (land[PS_CTRL]) ctrl_q   <= ldat[PS_CTRL];
      if (land[PS_RLD])  reload_q <= ldat[PS_RLD];
      if (land[PS_MAT])  match_q  <= ldat[PS_MAT];
      if (wr_any && bus_addr == A_IEN) ien_q <= bus_wdata[NFLAG-1:0];
      if (wr_any && bus_addr == A_WEN) wen_q <= bus_wdata[NFLAG-1:0];
    end
  end

  count_core #(.W(DATA_W), .NFL(NFLAG)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (soft_rst),
    .run        (ctrl_q[CT_RUN]),
    .auto_rld   (ctrl_q[CT_AR]),
    .cmp_en     (ctrl_q[CT_CE]),
    .reload     (reload_q),
    .match_val  (match_q),
    .cnt_ld     (land[PS_CNT]),
    .cnt_ld_val (ldat[PS_CNT]),
    .trg        (land[PS_TRG]),
    .w1c_we     (wr_any && bus_addr == A_STAT),
    .w1c_mask   (bus_wdata[NFLAG-1:0]),
    .count      (count_w),
    .status     (stat_w)
  );

  always_comb begin
    case (bus_addr)
      A_ID:    bus_rdata = DATA_W'({REV_MAJOR, REV_MINOR});
      A_SYS:   bus_rdata = DATA_W'(done_q);
      A_STAT:  bus_rdata = DATA_W'(stat_w);
      A_IEN:   bus_rdata = DATA_W'(ien_q);
      A_WEN:   bus_rdata = DATA_W'(wen_q);
      A_CTRL:  bus_rdata = ctrl_q;
      A_CNT:   bus_rdata = count_w;
      A_RLD:   bus_rdata = reload_q;
      A_PEND:  bus_rdata = DATA_W'(pend);
      A_MAT:   bus_rdata = match_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq  = |(stat_w & ien_q);
  assign wake = |(stat_w & wen_q);

  // R9
  sreset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (count_w == '0) && (stat_w == '0) && (pend == '0) && !done_q && (ctrl_q == '0));
  // R9
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !soft_rst) |=> done_q);
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_w != '0) && (ien_q != '0));
  // R8
  trig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (land[PS_TRG] && !land[PS_CNT] && !soft_rst) |=> count_w == $past(reload_q));
endmodule

// File: tb/sim_upcount_timer.sv
module sim_upcount_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq, wake;
  int          checks = 0;
  int          errors = 0;
  bit          summary_done = 1'b0;

  always #2 clk = ~clk;

  upcount_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wake(wake)
  );

  // entry: op[79:78] (0 write, 1 read-check, 2 idle), addr[77:70],
  // data[69:38], expected[37:6], irq[5], wake[4], requirement[3:0]
  localparam int NV = 63;
  localparam logic [79:0] VEC [NV] = '{
    {2'd1, 8'h00, 32'h0,        32'h21,       1'b0, 1'b0, 4'd1},  // R1 id
    {2'd1, 8'h14, 32'h0,        32'h1,        1'b0, 1'b0, 4'd9},  // R9 done after reset
    {2'd1, 8'h44, 32'h0,        32'h0,        1'b0, 1'b0, 4'd10}, // R10 unmapped
    {2'd0, 8'h28, 32'hFFFFFFFC, 32'h0,        1'b0, 1'b0, 4'd2},
    {2'd1, 8'h34, 32'h0,        32'h2,        1'b0, 1'b0, 4'd2},  // R2 pending
    {2'd1, 8'h34, 32'h0,        32'h2,        1'b0, 1'b0, 4'd2},
    {2'd1, 8'h28, 32'h0,        32'hFFFFFFFC, 1'b0, 1'b0, 4'd2},
    {2'd1, 8'h34, 32'h0,        32'h0,        1'b0, 1'b0, 4'd2},
    {2'd0, 8'h1C, 32'h2,        32'h0,        1'b0, 1'b0, 4'd7},
    {2'd0, 8'h2C, 32'h10,       32'h0,        1'b0, 1'b0, 4'd4},
    {2'd0, 8'h24, 32'h3,        32'h0,        1'b0, 1'b0, 4'd3},
    {2'd2, 8'h00, 32'd6,        32'h0,        1'b0, 1'b0, 4'd0},
    {2'd1, 8'h18, 32'h0,        32'h2,        1'b1, 1'b0, 4'd4},  // R4 overflow, R7 irq
    {2'd1, 8'h28, 32'h0,        32'h11,       1'b1, 1'b0, 4'd4},  // R4 reload
    {2'd0, 8'h18, 32'h2,        32'h0,        1'b0, 1'b0, 4'd6},
    {2'd1, 8'h18, 32'h0,        32'h0,        1'b0, 1'b0, 4'd6},  // R6 cleared
    {2'd0, 8'h24, 32'h0,        32'h0,        1'b0, 1'b0, 4'd3},
    {2'd2, 8'h00, 32'd3,        32'h0,        1'b0, 1'b0, 4'd0},
    {2'd0, 8'h28, 32'h100,      32'h0,        1'b0, 1'b0, 4'd5},
    {2'd0, 8'h38, 32'h103,      32'h0,        1'b0, 1'b0, 4'd5},
    {2'd0, 8'h24, 32'h41,       32'h0,        1'b0, 1'b0, 4'd5},
    {2'd2, 8'h00, 32'd5,        32'h0,        1'b0, 1'b0, 4'd0},
    {2'd1, 8'h18, 32'h0,        32'h0,        1'b0, 1'b0, 4'd5},  // R5 not yet
    {2'd1, 8'h18, 32'h0,        32'h1,        1'b0, 1'b0, 4'd5},  // R5 match
    {2'd1, 8'h28, 32'h0,        32'h105,      1'b0, 1'b0, 4'd3},  // R3 counting
    {2'd0, 8'h1C, 32'h1,        32'h0,        1'b0, 1'b0, 4'd7},
    {2'd1, 8'h18, 32'h0,        32'h1,        1'b1, 1'b0, 4'd7},  // R7
    {2'd0, 8'h18, 32'h6,        32'h0,        1'b0, 1'b0, 4'd6},
    {2'd1, 8'h18, 32'h0,        32'h1,        1'b1, 1'b0, 4'd6},  // R6 zero bits
    {2'd0, 8'h18, 32'h1,        32'h0,        1'b0, 1'b0, 4'd6},
    {2'd1, 8'h18, 32'h0,        32'h0,        1'b0, 1'b0, 4'd6},
    {2'd0, 8'h24, 32'h0,        32'h0,        1'b0, 1'b0, 4'd8},
    {2'd2, 8'h00, 32'd3,        32'h0,        1'b0, 1'b0, 4'd0},
    {2'd0, 8'h2C, 32'h50,       32'h0,        1'b0, 1'b0, 4'd8},
    {2'd0, 8'h30, 32'h0,        32'h0,        1'b0, 1'b0, 4'd8},
    {2'd1, 8'h34, 32'h0,        32'hC,        1'b0, 1'b0, 4'd2},  // R2 two pending
    {2'd2, 8'h00, 32'd1,        32'h0,        1'b0, 1'b0, 4'd0},
    {2'd1, 8'h28, 32'h0,        32'h50,       1'b0, 1'b0, 4'd8},  // R8 trigger
    {2'd0, 8'h28, 32'hFFFFFFFE, 32'h0,        1'b0, 1'b0, 4'd4},
    {2'd0, 8'h24, 32'h1,        32'h0,        1'b0, 1'b0, 4'd4},
    {2'd2, 8'h00, 32'd4,        32'h0,        1'b0, 1'b0, 4'd0},
    {2'd1, 8'h28, 32'h0,        32'h0,        1'b0, 1'b0, 4'd4},  // R4 wrap to zero
    {2'd1, 8'h18, 32'h0,        32'h2,        1'b0, 1'b0, 4'd4},
    {2'd0, 8'h20, 32'h2,        32'h0,        1'b0, 1'b0, 4'd7},
    {2'd1, 8'h18, 32'h0,        32'h2,        1'b0, 1'b1, 4'd7},  // R7 wake
    {2'd0, 8'h10, 32'h2,        32'h0,        1'b0, 1'b0, 4'd9},
    {2'd1, 8'h14, 32'h0,        32'h0,        1'b0, 1'b0, 4'd9},  // R9 done low
    {2'd1, 8'h14, 32'h0,        32'h1,        1'b0, 1'b0, 4'd9},
    {2'd1, 8'h18, 32'h0,        32'h0,        1'b0, 1'b0, 4'd9},
    {2'd1, 8'h24, 32'h0,        32'h0,        1'b0, 1'b0, 4'd9},
    {2'd1, 8'h28, 32'h0,        32'h0,        1'b0, 1'b0, 4'd9},
    {2'd1, 8'h20, 32'h0,        32'h0,        1'b0, 1'b0, 4'd9},
    {2'd0, 8'h28, 32'h5,        32'h0,        1'b0, 1'b0, 4'd2},
    {2'd0, 8'h28, 32'h7,        32'h0,        1'b0, 1'b0, 4'd2},
    {2'd1, 8'h28, 32'h0,        32'h0,        1'b0, 1'b0, 4'd2},  // R2 old value
    {2'd1, 8'h28, 32'h0,        32'h5,        1'b0, 1'b0, 4'd2},
    {2'd1, 8'h28, 32'h0,        32'h7,        1'b0, 1'b0, 4'd2},  // R2 in order
    {2'd0, 8'h24, 32'h1,        32'h0,        1'b0, 1'b0, 4'd11},
    {2'd0, 8'h28, 32'h200,      32'h0,        1'b0, 1'b0, 4'd11},
    {2'd2, 8'h00, 32'd2,        32'h0,        1'b0, 1'b0, 4'd0},
    {2'd1, 8'h28, 32'h0,        32'h200,      1'b0, 1'b0, 4'd11}, // R11 load wins
    {2'd1, 8'h28, 32'h0,        32'h201,      1'b0, 1'b0, 4'd3},  // R3
    {2'd0, 8'h24, 32'h0,        32'h0,        1'b0, 1'b0, 4'd3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_check(input string tag, input logic [7:0] a, input logic [31:0] e,
                           input logic ei, input logic ew);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, e);
    chk({tag, " irq/wake"}, {30'b0, irq, wake}, {30'b0, ei, ew});
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // reset state (R9, R3)
    bus_check("R9 reset done during reset", 8'h14, 32'h0, 1'b0, 1'b0);
    bus_check("R3 reset count", 8'h28, 32'h0, 1'b0, 1'b0);
    bus_check("R2 reset pending", 8'h34, 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [79:0] e;
      string       tg;
      e  = VEC[i];
      tg = $sformatf("R%0d vec %0d", e[3:0], i);
      case (e[79:78])
        2'd0: bus_write(e[77:70], e[69:38]);
        2'd1: bus_check(tg, e[77:70], e[37:6], e[5], e[4]);
        default: repeat (int'(e[69:38])) @(negedge clk);
      endcase
    end
    // hard reset while running (R9)
    bus_write(8'h24, 32'h1);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    bus_check("R9 hard reset count", 8'h28, 32'h0, 1'b0, 1'b0);
    bus_check("R9 hard reset done low", 8'h14, 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_check("R9 done after release", 8'h14, 32'h1, 1'b0, 1'b0);
    bus_check("R3 stopped after reset", 8'h28, 32'h0, 1'b0, 1'b0);
    bus_check("R1 id after reset", 8'h00, 32'h21, 1'b0, 1'b0);
    finish_run();
  end
endmodule